// File: doc/BRIEF.md
# Prescaled Interval Timer Channel

This block is a single counting channel meant to sit behind a register bank in a multi-channel timer peripheral. A 16-bit count advances on ticks from a power-of-two prescaler, or on every clock when the prescaler is off. The count runs upward or downward. It wraps either at a programmed interval value or at the full 16-bit range. Three match comparators watch the count as it moves. A wrap or a match sets a sticky status flag, and one interrupt line reports any flag whose enable bit is set.

The register bank passes the clock-control value, the interval value, the three match values and the interrupt enables straight through as plain levels. The counter-control value is written into the channel by a one-cycle write strobe. The channel keeps the mode bits of that value. Bit 4 of the written data is a reset-counter strobe and is not kept. A separate one-cycle clear strobe wipes the status vector. No port carries a stream of data, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status level.

Top module: `tmr_channel`

## Requirements
- R1: After reset the count is 0, the status vector is 0 and the interrupt is low. The stored control comes out of reset with bit 0 (disable) set and bits 1 and 2 clear, so the count holds at 0 until control is written.
- R2: With clk_ctrl bit 0 clear, the count advances by one on every clock in which the channel is enabled.
- R3: With clk_ctrl bit 0 set, the count advances once every 2^(N+1) clocks, where N is clk_ctrl[4:1].
- R4: While stored control bit 0 is 1, the count keeps its value and no status bit is set.
- R5: With control bit 1 clear (full range), an upward step from 0xFFFF gives 0 and a downward step from 0 gives 0xFFFF. Either wrap sets status bit 4.
- R6: With control bit 1 set (interval mode), an upward step from the interval value (or from above it) gives 0. The wrap sets status bit 0.
- R7: With control bit 2 set, the count decrements. A step from 0 loads the top of the active range: the interval value in interval mode, 0xFFFF otherwise.
- R8: A step that brings the count to the value of match i (i = 0, 1, 2; match i sits at match_vals[16*i+15:16*i]) sets status bit i+1. Status bit 5 stays 0.
- R9: A control write with data bit 4 set drives the count to 0 at that clock edge. Bit 4 is not stored, so a later write without it leaves the count running.
- R10: irq equals the OR over all bits of status AND irq_en.
- R11: Status bits stay set until stat_clr is pulsed. When a flag event and stat_clr fall in the same cycle, that event's bit ends up set.
- R12: Any change of clk_ctrl, and any counter reset, restarts the prescaler. The first advance after it comes one full period later, and no advance occurs in the cycle of the change.
- R13: A written control value takes effect from the clock after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ctrl | input | 5 | Bit 0 prescaler enable, bits 4:1 prescale exponent N |
| ctl_we | input | 1 | One-cycle write strobe for counter control |
| ctl_wdata | input | 5 | Control data: bit 0 disable, bit 1 interval mode, bit 2 decrement, bit 4 reset-counter strobe, bit 3 ignored |
| intv | input | 16 | Interval (top of range in interval mode) |
| match_vals | input | 48 | Three packed 16-bit match values, match 0 in the low bits |
| irq_en | input | 6 | Per-bit interrupt enable |
| stat_clr | input | 1 | One-cycle clear of all status bits |
| count | output | 16 | Current count |
| status | output | 6 | Sticky flags: 0 interval wrap, 1..3 matches, 4 overflow wrap, 5 always 0 |
| irq | output | 1 | Interrupt request |

## Verification
A tick decided in one cycle changes count and the matching status bit at the next rising edge. A control write or a counter reset acts at the edge that samples its strobe. irq follows status with no extra register, so it also changes at that edge. The bench drives all inputs on the falling edge. Before each rising edge it computes the expected next state from the requirements, and it compares count, status and irq on the following falling edge, every cycle. Sweeps over interval values, match values, count directions and prescale exponents therefore catch a result that arrives one cycle early or late.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W     = 16;
  localparam int PS_W      = 4;
  localparam int NUM_MATCH = 3;
  localparam int ST_W      = NUM_MATCH + 3;
  localparam int ST_IV     = 0;
  localparam int ST_OV     = NUM_MATCH + 1;
  localparam int CTL_W     = 3;
  localparam int CTL_DIS   = 0;
  localparam int CTL_IMODE = 1;
  localparam int CTL_DEC   = 2;
  localparam int WD_RST    = 4;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ps_en,
  input  logic [PS_W-1:0] ps_sel,
  input  logic            restart,
  output logic            tick
);
  localparam int DIV_W = 2 ** PS_W;

  logic [PS_W:0]    cfg_q;
  logic [DIV_W-1:0] div_q;
  logic [PS_W:0]    shamt;
  logic [DIV_W:0]   last_w;
  logic             chg, at_end;

  assign shamt  = {1'b0, ps_sel} + 1'b1;
  assign last_w = ({{DIV_W{1'b0}}, 1'b1} << shamt) - 1'b1;
  assign at_end = (div_q == last_w[DIV_W-1:0]);
  assign chg    = ({ps_sel, ps_en} != cfg_q);
  assign tick   = !chg && !restart && (!ps_en || at_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      div_q <= '0;
    end else begin
      cfg_q <= {ps_sel, ps_en};
      if (chg || restart || !ps_en) div_q <= '0;
      else if (at_end)              div_q <= '0;
      else                          div_q <= div_q + 1'b1;
    end
  end

  // R3: a divided tick is never followed directly by another one
  a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ps_en) |=> !tick);
  // R12: no tick in the cycle a setting change is seen
  a_r12_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (chg || restart) |-> !tick);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             dis,
  input  logic             imode,
  input  logic             dec,
  input  logic             rs,
  input  logic [CNT_W-1:0] intv,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nx,
  output logic             adv,
  output logic             wrap_iv,
  output logic             wrap_ov
);
  logic [CNT_W-1:0] top_v;
  logic             wrap;

  assign top_v = imode ? intv : {CNT_W{1'b1}};
  assign adv   = tick && !dis && !rs;

  always_comb begin
    cnt_nx = cnt_q;
    wrap   = 1'b0;
    if (!dec) begin
      if (cnt_q >= top_v) begin
        cnt_nx = '0;
        wrap   = 1'b1;
      end else begin
        cnt_nx = cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q == '0) begin
        cnt_nx = top_v;
        wrap   = 1'b1;
      end else begin
        cnt_nx = cnt_q - 1'b1;
      end
    end
  end

  assign wrap_iv = adv && wrap && imode;
  assign wrap_ov = adv && wrap && !imode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (rs)  cnt_q <= '0;
    else if (adv) cnt_q <= cnt_nx;
  end

  // R4: disabled channel holds its count
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dis && !rs) |=> (cnt_q == $past(cnt_q)));
  // R9: reset strobe leaves count at zero
  a_r9_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rs |=> (cnt_q == '0));
  // R6: upward step at the interval top returns to zero
  a_r6_top_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && imode && !dec && cnt_q == intv) |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int CNT_W     = 16,
  parameter int NUM_MATCH = 3
) (
  input  logic                       adv,
  input  logic [CNT_W-1:0]           cnt_nx,
  input  logic [NUM_MATCH*CNT_W-1:0] match_vals,
  output logic [NUM_MATCH-1:0]       hit
);
  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_cmp
    assign hit[i] = adv && (cnt_nx == match_vals[i*CNT_W +: CNT_W]);
  end
endmodule

// File: rtl/tmr_status.sv
module tmr_status #(
  parameter int ST_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] set_v,
  input  logic            clr,
  output logic [ST_W-1:0] st_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= (clr ? '0 : st_q) | set_v;
  end

  // R11: without a clear, no set bit drops
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((st_q & $past(st_q)) == $past(st_q)));
  // R11: an event in the clear cycle survives
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((st_q & $past(set_v)) == $past(set_v)));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int PW = PS_W,
  parameter int NM = NUM_MATCH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PW:0]     clk_ctrl,
  input  logic            ctl_we,
  input  logic [4:0]      ctl_wdata,
  input  logic [CW-1:0]   intv,
  input  logic [NM*CW-1:0] match_vals,
  input  logic [NM+2:0]   irq_en,
  input  logic            stat_clr,
  output logic [CW-1:0]   count,
  output logic [NM+2:0]   status,
  output logic            irq
);
  localparam int SW = NM + 3;

  logic [CTL_W-1:0] ctrl_q;
  logic             rs, tick, adv, wrap_iv, wrap_ov;
  logic [CW-1:0]    cnt_nx;
  logic [NM-1:0]    hit;
  logic [SW-1:0]    set_v;
  logic             ctl_unused;

  assign ctl_unused = ctl_wdata[3];
  assign rs = ctl_we && ctl_wdata[WD_RST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= CTL_W'(1) << CTL_DIS;
    else if (ctl_we) ctrl_q <= ctl_wdata[CTL_W-1:0];
  end

  tmr_prescaler #(.PS_W(PW)) u_ps (
    .clk(clk), .rst_n(rst_n), .ps_en(clk_ctrl[0]), .ps_sel(clk_ctrl[PW:1]),
    .restart(rs), .tick(tick)
  );

  tmr_counter #(.CNT_W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dis(ctrl_q[CTL_DIS]),
    .imode(ctrl_q[CTL_IMODE]), .dec(ctrl_q[CTL_DEC]), .rs(rs), .intv(intv),
    .cnt_q(count), .cnt_nx(cnt_nx), .adv(adv), .wrap_iv(wrap_iv), .wrap_ov(wrap_ov)
  );

  tmr_match #(.CNT_W(CW), .NUM_MATCH(NM)) u_match (
    .adv(adv), .cnt_nx(cnt_nx), .match_vals(match_vals), .hit(hit)
  );

  assign set_v = {1'b0, wrap_ov, hit, wrap_iv};

  tmr_status #(.ST_W(SW)) u_st (
    .clk(clk), .rst_n(rst_n), .set_v(set_v), .clr(stat_clr), .st_q(status)
  );

  assign irq = |(status & irq_en);

  // R8: the unused top flag never rises
  a_r8_top_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
    !status[SW-1]);
  // R10: irq is quiet when status is empty
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> !irq);
endmodule

// File: tb/test_tmr_channel.sv
module test_tmr_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  clk_ctrl = '0;
  logic        ctl_we = 1'b0;
  logic [4:0]  ctl_wdata = '0;
  logic [15:0] intv = '0;
  logic [47:0] match_vals = '0;
  logic [5:0]  irq_en = '0;
  logic        stat_clr = 1'b0;
  logic [15:0] count;
  logic [5:0]  status;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  int m_cnt = 0, m_stat = 0, m_div = 0, m_cfg = 0, m_ctrl = 1;

  always #5 clk = ~clk;

  tmr_channel i_tmr_channel (
    .clk(clk), .rst_n(rst_n), .clk_ctrl(clk_ctrl), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .intv(intv), .match_vals(match_vals),
    .irq_en(irq_en), .stat_clr(stat_clr), .count(count), .status(status), .irq(irq)
  );

  task automatic check_now();
    logic exp_irq;
    exp_irq = |(6'(m_stat) & irq_en);
    n_chk++;
    if (count !== 16'(m_cnt) || status !== 6'(m_stat) || irq !== exp_irq) begin
      n_fail++;
      $display("FAIL %s count=%h/%h status=%b/%b irq=%b/%b (actual/expected)",
               cur_req, count, 16'(m_cnt), status, 6'(m_stat), irq, exp_irq);
    end
  endtask

  task automatic step();
    int per, top, nx, set, cfg;
    bit chg, rs, tk, adv, wrap;
    cfg = int'(clk_ctrl);
    chg = (cfg != m_cfg);
    rs  = ctl_we && ctl_wdata[4];
    per = clk_ctrl[0] ? (1 << (int'(clk_ctrl[4:1]) + 1)) : 1;
    tk  = !chg && !rs && (!clk_ctrl[0] || m_div == per - 1);
    adv = tk && !m_ctrl[0];
    top = m_ctrl[1] ? int'(intv) : 65535;
    wrap = 0;
    if (!m_ctrl[2]) begin
      if (m_cnt >= top) begin nx = 0; wrap = 1; end else nx = m_cnt + 1;
    end else begin
      if (m_cnt == 0) begin nx = top; wrap = 1; end else nx = m_cnt - 1;
    end
    set = 0;
    if (adv) begin
      if (wrap) set |= m_ctrl[1] ? 1 : 16;
      for (int i = 0; i < 3; i++)
        if (nx == int'(match_vals[i*16 +: 16])) set |= (2 << i);
    end
    @(posedge clk);
    m_stat = (stat_clr ? 0 : m_stat) | set;
    if (rs) m_cnt = 0; else if (adv) m_cnt = nx;
    if (chg || rs || !clk_ctrl[0]) m_div = 0;
    else m_div = (m_div == per - 1) ? 0 : m_div + 1;
    m_cfg = cfg;
    if (ctl_we) m_ctrl = int'(ctl_wdata[2:0]);
    @(negedge clk);
    check_now();
    ctl_we = 1'b0;
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic wr_ctrl(logic [4:0] v);
    ctl_we = 1'b1;
    ctl_wdata = v;
    step();
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired during %s", cur_req);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check_now();
    rst_n = 1'b1;
    run(6);

    cur_req = "R2";
    match_vals = {16'd300, 16'd20, 16'd5};
    wr_ctrl(5'b00000);
    run(40);

    cur_req = "R10";
    for (int b = 0; b < 6; b++) begin
      irq_en = 6'(1 << b);
      run(3);
    end
    irq_en = 6'h3f;

    cur_req = "R11";
    stat_clr = 1'b1;
    step();
    intv = 16'd0;
    wr_ctrl(5'b10010);
    run(6);
    stat_clr = 1'b0;
    run(4);

    cur_req = "R6";
    for (int iv = 1; iv <= 6; iv++) begin
      intv = 16'(iv);
      stat_clr = 1'b1; step(); stat_clr = 1'b0;
      wr_ctrl(5'b10010);
      run(2 * (iv + 1) + 3);
    end
    cur_req = "R7";
    for (int iv = 1; iv <= 6; iv++) begin
      intv = 16'(iv);
      stat_clr = 1'b1; step(); stat_clr = 1'b0;
      wr_ctrl(5'b10110);
      run(2 * (iv + 1) + 3);
    end

    cur_req = "R8";
    intv = 16'd7;
    for (int d = 0; d < 2; d++) begin
      wr_ctrl(d == 0 ? 5'b10010 : 5'b10110);
      for (int mv = 0; mv < 8; mv++) begin
        match_vals = {16'(7 - mv), 16'((mv + 3) % 8), 16'(mv)};
        stat_clr = 1'b1; step(); stat_clr = 1'b0;
        run(10);
      end
    end

    cur_req = "R3";
    intv = 16'd9;
    wr_ctrl(5'b10010);
    for (int n = 0; n < 4; n++) begin
      clk_ctrl = {4'(n), 1'b1};
      run((2 << n) * 12);
    end
    cur_req = "R12";
    clk_ctrl = {4'd1, 1'b1};
    run(3);
    clk_ctrl = {4'd2, 1'b1};
    run(20);
    wr_ctrl(5'b10010);
    run(20);
    clk_ctrl = 5'b0;
    run(5);

    cur_req = "R4";
    wr_ctrl(5'b00011);
    stat_clr = 1'b1; step(); stat_clr = 1'b0;
    run(20);

    cur_req = "R13";
    wr_ctrl(5'b00000);
    run(5);
    wr_ctrl(5'b00100);
    run(5);

    cur_req = "R9";
    wr_ctrl(5'b10000);
    run(10);
    wr_ctrl(5'b00000);
    run(6);

    cur_req = "R5";
    stat_clr = 1'b1; step(); stat_clr = 1'b0;
    wr_ctrl(5'b10100);
    run(6);
    stat_clr = 1'b1; step(); stat_clr = 1'b0;
    wr_ctrl(5'b00000);
    run(12);

    finish_up();
  end
endmodule